// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one starting column into the column address for every beat of an SDRAM burst. When a burst begins, it captures the burst length and the ordering from the mode settings. It then presents one column per clock, each with a valid strobe, and raises a flag on the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the starting column. They step through that block either in sequential order or in interleaved order. A full-page burst walks the whole column range, wrapping at the top, and keeps going until a stop arrives or a new burst begins.

A new starting column is accepted on any clock and takes over at once from whatever burst is running. A stop input ends the current burst: no further columns are presented after it. Data, banks, rows and command sequencing are handled elsewhere.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held, and in the first cycle after it, col_valid and col_last are both 0.
- R2: When start is high at a clock edge, the next cycle shows col_valid=1 and col=start_col as beat 0. This applies even if a burst is running or stop is high in the same cycle.
- R3: len_sel is captured at start with this encoding: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats, and any value from 4 to 7 gives a full page. Changes to len_sel and ilv during a burst have no effect on it.
- R4: Sequential fixed burst (ilv=0) of length BL: beat k has the starting column's bits above log2(BL) unchanged. Its low log2(BL) bits equal (start low bits + k) mod BL.
- R5: Interleaved fixed burst (ilv=1): beat k has the starting column's upper bits unchanged. Its low log2(BL) bits equal the start low bits XOR k.
- R6: Full-page burst: beat k is (start_col + k) mod 2^COL_W, whatever the value of ilv. Beats continue beyond 2^COL_W until stop or start.
- R7: col_last is 1 exactly on beat BL-1 of a fixed burst. In the cycle after that beat, col_valid is 0 unless a start arrived.
- R8: col_last is never 1 during a full-page burst.
- R9: If stop is high at an edge while col_valid is 1 and start is low, col_valid is 0 in the next cycle. A stop while idle leaves col_valid at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new burst at start_col |
| start_col | input | COL_W | Starting column of the new burst |
| len_sel | input | 3 | Burst length code (see R3) |
| ilv | input | 1 | 1 selects interleaved ordering for fixed bursts |
| stop | input | 1 | Terminate the running burst |
| col_valid | output | 1 | col carries a burst beat |
| col | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
With a 5-bit column, every starting column is swept through each fixed length in both orderings. This separates a wrap that is confined to the aligned block from a carry that leaks into the upper bits. It also separates the XOR pattern from the additive one, at every alignment. Full-page runs start near the top of the range and go past 32 beats with ilv set, which shows that the wrap covers the full range and that ordering is ignored. Restarts in mid-burst, a stop during fixed and full-page bursts, a stop while idle, and start together with stop each show which input has priority.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_sel,
  input  logic             ilv,
  input  logic             stop,
  output logic             col_valid,
  output logic [COL_W-1:0] col,
  output logic             col_last
);
  localparam logic [COL_W-1:0] ONES = {COL_W{1'b1}};

  logic [COL_W-1:0] base_q, cnt_q, mask, low;
  logic [1:0]       lg_q;
  logic             fp_q, ilv_q, vld_q;

  assign mask      = fp_q ? ONES : ~(ONES << lg_q);
  assign low       = (ilv_q && !fp_q) ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign col       = (base_q & ~mask) | (low & mask);
  assign col_valid = vld_q;
  assign col_last  = vld_q && !fp_q && (cnt_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      lg_q   <= '0;
      fp_q   <= 1'b0;
      ilv_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else if (start) begin
      base_q <= start_col;
      cnt_q  <= '0;
      lg_q   <= len_sel[1:0];
      fp_q   <= len_sel[2];
      ilv_q  <= ilv;
      vld_q  <= 1'b1;
    end else if (vld_q) begin
      if (stop || col_last) vld_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col == $past(start_col)));
  // R7
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start) |=> !col_valid);
  // R9
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start && col_valid) |=> !col_valid);
  // R9
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_valid && !start) |=> !col_valid);
  // R8
  fp_nolast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_q |-> !col_last);
  // R4
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !start && !stop && !col_last && !fp_q)
      |=> (col[COL_W-1:3] == $past(col[COL_W-1:3])));
  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
endmodule

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;
  localparam int CW = 5;
  localparam int NC = 1 << CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ilv = 1'b0, stop = 1'b0;
  logic [CW-1:0] start_col = '0;
  logic [2:0] len_sel = '0;
  logic col_valid, col_last;
  logic [CW-1:0] col;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_burst_colgen #(.COL_W(CW)) u_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_sel(len_sel), .ilv(ilv), .stop(stop),
    .col_valid(col_valid), .col(col), .col_last(col_last));

  task automatic chk(string req, bit ok, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int b, int lg, bit fp, bit il, int k);
    int m, lo;
    if (fp) return (b + k) % NC;
    m  = (1 << lg) - 1;
    lo = il ? ((b & m) ^ k) : (((b & m) + k) & m);
    return (b & ~m) | lo;
  endfunction

  task automatic begin_burst(int b, int ls, bit il);
    @(negedge clk);
    start = 1'b1; start_col = CW'(b); len_sel = 3'(ls); ilv = il; stop = 1'b0;
    @(negedge clk);
    start = 1'b0;
    len_sel = 3'(~ls); ilv = ~il;
  endtask

  task automatic beat(string req, int b, int lg, bit fp, bit il, int k);
    bit lst;
    lst = !fp && (k == (1 << lg) - 1);
    chk(req, col_valid === 1'b1, int'(col_valid), 1);
    chk(req, int'(col) == exp_col(b, lg, fp, il, k), int'(col), exp_col(b, lg, fp, il, k));
    chk("R7/R8 last", col_last === lst, int'(col_last), int'(lst));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", col_valid === 1'b0, int'(col_valid), 0);
    chk("R1 reset last", col_last === 1'b0, int'(col_last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", col_valid === 1'b0, int'(col_valid), 0);

    // R3 R4 R5 R7 sweep over every start, fixed length and ordering
    for (int il = 0; il < 2; il++)
      for (int lg = 0; lg < 4; lg++)
        for (int b = 0; b < NC; b++) begin
          begin_burst(b, lg, bit'(il));
          for (int k = 0; k < (1 << lg); k++) begin
            beat(il ? "R5 interleaved" : "R4 sequential", b, lg, 1'b0, bit'(il), k);
            @(negedge clk);
          end
          chk("R7 end", col_valid === 1'b0, int'(col_valid), 0);
        end

    // R6 R8 full page wraps past the range, ilv ignored; then stop (R9)
    for (int s = 0; s < 4; s++) begin
      int b;
      b = NC - 3 + s * 7;
      begin_burst(b % NC, 4 + s, bit'(s & 1));
      for (int k = 0; k < NC + 5; k++) begin
        beat("R6 full page", b % NC, 0, 1'b1, 1'b0, k);
        if (k < NC + 4) @(negedge clk);
      end
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk("R9 stop full page", col_valid === 1'b0, int'(col_valid), 0);
    end

    // R9 stop inside fixed burst
    begin_burst(9, 3, 1'b0);
    beat("R9 pre", 9, 3, 1'b0, 1'b0, 0);
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R9 stop fixed", col_valid === 1'b0, int'(col_valid), 0);

    // R9 stop while idle has no effect
    stop = 1'b1;
    repeat (3) @(negedge clk);
    stop = 1'b0;
    chk("R9 idle stop", col_valid === 1'b0, int'(col_valid), 0);

    // R2 restart in mid-burst
    begin_burst(3, 3, 1'b1);
    beat("R2 first", 3, 3, 1'b0, 1'b1, 0);
    @(negedge clk);
    beat("R2 first", 3, 3, 1'b0, 1'b1, 1);
    begin_burst(22, 2, 1'b0);
    for (int k = 0; k < 4; k++) begin
      beat("R2 restart", 22, 2, 1'b0, 1'b0, k);
      @(negedge clk);
    end
    chk("R2 restart end", col_valid === 1'b0, int'(col_valid), 0);

    // R2 start and stop together: start wins
    begin_burst(30, 4, 1'b0);
    @(negedge clk);
    start = 1'b1; start_col = CW'(17); len_sel = 3'd1; ilv = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    beat("R2 start over stop", 17, 1, 1'b0, 1'b1, 0);
    @(negedge clk);
    beat("R2 start over stop", 17, 1, 1'b0, 1'b1, 1);
    @(negedge clk);
    chk("R2 end", col_valid === 1'b0, int'(col_valid), 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule